// File: doc/BRIEF.md
# Calendar Clock Register File with Index/Data Access

The block keeps a binary calendar (seconds, minutes, hours, weekday, day of month, month, year) and exposes it through a two-port access scheme. A write to the index port stores the number of an internal register; each later read strobe on the data port returns that register's contents one cycle later. The calendar advances on a one-cycle second tick and carries through minutes, hours, days, months and years. The day-of-month rollover follows month lengths and the leap-year rule. Software sets the starting date by pulsing a load strobe with the parallel preset inputs.

Three control registers return fixed values, except for an update-in-progress flag that flips on every read of the first control register. Unsupported accesses raise a one-cycle error pulse: data-port writes, and reads of the alarm slots, the fourth control register or any unlisted index. A separate counter emits a one-cycle periodic interrupt pulse at a fixed cycle interval.

Top module: `rtc_regfile`

## Requirements
- R1: A write on the index port stores the 8-bit index. Each data-port read returns, one cycle later with rd_valid high, the register that index selects: seconds 0x00, minutes 0x02, hours 0x04, weekday 0x06 (0 to 6), day of month 0x07. The index is kept across any number of reads.
- R2: Reading index 0x0A returns {flag, 7'h26}. The flag is 1 after reset and is inverted by every read of 0x0A, so successive reads give 0xA6, 0x26, 0xA6.
- R3: Index 0x0B always reads 0x46, and index 0x0C always reads 0x00.
- R4: Index 0x08 returns the month as 1 to 12.
- R5: Index 0x09 returns the stored years-since-1900 count minus 52, modulo 256.
- R6: A data read with index 0x0D or any index not listed in R1 to R5 returns 0x00 and pulses access_err in the same cycle as rd_valid. A data-port write pulses access_err in the following cycle and changes nothing else.
- R7: When preset_load is high on a clock edge, the calendar takes the preset values on that edge, even if sec_tick is high too.
- R8: With sec_tick high for one cycle, seconds advance by one. 59 wraps to 0 and carries to minutes, 59 minutes carry to hours, and hour 23 wraps to 0. That wrap advances the weekday (6 wraps to 0) and the day. With no tick and no load the calendar holds.
- R9: The day wraps to 1 after the last day of the month: 30 for months 4, 6, 9 and 11, 31 for the other months, and 28 for month 2 (29 when the year count is a multiple of 4 other than 0 or 200). From month 12 the wrap goes to month 1 and increments the year.
- R10: periodic_irq is high for exactly one cycle every PERIOD_CYCLES cycles. The first pulse comes PERIOD_CYCLES cycles after reset is released.
- R11: After reset, rd_valid, access_err and periodic_irq are 0. The calendar reads 00:00:00, weekday 4, day 1, month 1, year count 70.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sec_tick | input | 1 | One-cycle pulse per elapsed second |
| preset_load | input | 1 | Load strobe for the preset date and time |
| preset_sec | input | 6 | Preset seconds |
| preset_min | input | 6 | Preset minutes |
| preset_hour | input | 5 | Preset hours, 0 to 23 |
| preset_dow | input | 3 | Preset weekday, 0 to 6 |
| preset_dom | input | 5 | Preset day of month, 1 to 31 |
| preset_mon | input | 4 | Preset month, 1 to 12 |
| preset_year | input | 8 | Preset years since 1900 |
| idx_wr | input | 1 | Index port write strobe |
| idx_wdata | input | 8 | Index value |
| data_rd | input | 1 | Data port read strobe |
| data_wr | input | 1 | Data port write strobe (unsupported) |
| rd_data | output | 8 | Read result |
| rd_valid | output | 1 | rd_data holds a new result |
| access_err | output | 1 | One-cycle pulse on an unsupported access |
| periodic_irq | output | 1 | Periodic interrupt pulse |

## Verification
The hardest case to reach from the ports is the calendar boundaries: the leap-day decision, the year carry and the century years. Reaching them by ticking from reset would take years of ticks. The stimulus instead loads a preset one second before each boundary (23:59:59 on the last day of a month, for several year counts) and applies a single tick. It then reads every field back through the index/data ports. Simultaneous load and tick, the flag flip on repeated reads of the first control register, and reads that reuse a stored index are driven the same way.

// File: rtl/rtc_regfile_pkg.sv
`timescale 1ns/1ps
// Shared register indices, fixed control values, calendar record and
// month-length helper for the calendar clock register file.
package rtc_regfile_pkg;

    localparam logic [7:0] IDX_SEC  = 8'h00;
    localparam logic [7:0] IDX_MIN  = 8'h02;
    localparam logic [7:0] IDX_HOUR = 8'h04;
    localparam logic [7:0] IDX_DOW  = 8'h06;
    localparam logic [7:0] IDX_DOM  = 8'h07;
    localparam logic [7:0] IDX_MON  = 8'h08;
    localparam logic [7:0] IDX_YEAR = 8'h09;
    localparam logic [7:0] IDX_CTLA = 8'h0A;
    localparam logic [7:0] IDX_CTLB = 8'h0B;
    localparam logic [7:0] IDX_CTLC = 8'h0C;

    localparam logic [6:0] CTLA_LOW   = 7'h26;
    localparam logic [7:0] CTLB_VALUE = 8'h46;
    localparam logic [7:0] CTLC_VALUE = 8'h00;

    typedef struct packed {
        logic [5:0] sec;
        logic [5:0] min;
        logic [4:0] hour;
        logic [2:0] dow;
        logic [4:0] dom;
        logic [3:0] mon;
        logic [7:0] year;   // years since 1900
    } cal_t;

    // Leap test over the 8-bit year range: 1900 and 2100 are not leap years.
    function automatic logic is_leap(input logic [7:0] y);
        return (y[1:0] == 2'b00) && (y != 8'd0) && (y != 8'd200);
    endfunction

    // Number of days in month m (1..12) of year y.
    function automatic logic [4:0] month_days(input logic [3:0] m, input logic [7:0] y);
        case (m)
            4'd2:                      return is_leap(y) ? 5'd29 : 5'd28;
            4'd4, 4'd6, 4'd9, 4'd11:   return 5'd30;
            default:                   return 5'd31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_calendar.sv
`timescale 1ns/1ps
// Calendar counters. Loads the preset record while load is high (load wins
// over tick), otherwise advances one second per tick with full carry through
// minutes, hours, days, months and years.
// Assumes preset values are in range (dom within the month, mon 1..12).
module rtc_calendar
    import rtc_regfile_pkg::*;
#(
    parameter int RESET_YEAR = 70,
    parameter int RESET_DOW  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic load,
    input  cal_t preset,
    output cal_t now
);

    localparam logic [7:0] RST_YEAR8 = 8'(RESET_YEAR);
    localparam logic [2:0] RST_DOW3  = 3'(RESET_DOW);

    cal_t       nxt;
    logic [4:0] last_day;

    // Next-state calendar: preset, one-second advance, or hold.
    always_comb begin
        nxt      = now;
        last_day = month_days(now.mon, now.year);
        if (load) begin
            nxt = preset;
        end else if (tick) begin
            if (now.sec != 6'd59) begin
                nxt.sec = now.sec + 6'd1;
            end else begin
                nxt.sec = 6'd0;
                if (now.min != 6'd59) begin
                    nxt.min = now.min + 6'd1;
                end else begin
                    nxt.min = 6'd0;
                    if (now.hour != 5'd23) begin
                        nxt.hour = now.hour + 5'd1;
                    end else begin
                        nxt.hour = 5'd0;
                        nxt.dow  = (now.dow >= 3'd6) ? 3'd0 : now.dow + 3'd1;
                        if (now.dom < last_day) begin
                            nxt.dom = now.dom + 5'd1;
                        end else begin
                            nxt.dom = 5'd1;
                            if (now.mon >= 4'd12) begin
                                nxt.mon  = 4'd1;
                                nxt.year = now.year + 8'd1;
                            end else begin
                                nxt.mon = now.mon + 4'd1;
                            end
                        end
                    end
                end
            end
        end
    end

    // Calendar state register with reset to the default date.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            now <= '{sec: 6'd0, min: 6'd0, hour: 5'd0, dow: RST_DOW3,
                     dom: 5'd1, mon: 4'd1, year: RST_YEAR8};
        end else begin
            now <= nxt;
        end
    end

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> now == $past(preset)); // R7
    AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load && now.sec == 6'd59) |=> now.sec == 6'd0); // R8
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load) |=> $stable(now)); // R8
    AST_DATE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        now.mon >= 4'd1 && now.mon <= 4'd12 && now.dom >= 5'd1); // R9

endmodule

// File: rtl/rtc_periodic.sv
`timescale 1ns/1ps
// Periodic interrupt generator: a free-running counter that emits a
// one-cycle pulse every PERIOD_CYCLES cycles and restarts on the pulse.
// Assumes PERIOD_CYCLES >= 2.
module rtc_periodic #(
    parameter int PERIOD_CYCLES = 1024
) (
    input  logic clk,
    input  logic rst_n,
    output logic irq
);

    localparam int CNT_W = (PERIOD_CYCLES > 2) ? $clog2(PERIOD_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD_CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    // Interval counter and registered pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            irq <= 1'b0;
        end else begin
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
            irq <= (cnt == LAST);
        end
    end

    AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq); // R10
    AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> cnt == '0); // R10

endmodule

// File: rtl/rtc_access.sv
`timescale 1ns/1ps
// Index/data access port: holds the selected index, returns the selected
// register one cycle after a read strobe, flips the update flag on reads of
// control register A and flags unsupported accesses.
// Assumes idx_wr and data_rd are not asserted in the same cycle.
module rtc_access
    import rtc_regfile_pkg::*;
#(
    parameter int YEAR_BIAS = 52
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idx_wr,
    input  logic [7:0] idx_wdata,
    input  logic       data_rd,
    input  logic       data_wr,
    input  cal_t       now,
    output logic [7:0] rd_data,
    output logic       rd_valid,
    output logic       err
);

    localparam logic [7:0] BIAS8 = 8'(YEAR_BIAS);

    logic [7:0] idx;
    logic       uip;
    logic [7:0] sel_data;
    logic       sel_ok;
    logic       read_a;

    // Decode the held index into read data and a supported flag.
    always_comb begin
        sel_ok   = 1'b1;
        sel_data = 8'h00;
        case (idx)
            IDX_SEC:  sel_data = {2'b00, now.sec};
            IDX_MIN:  sel_data = {2'b00, now.min};
            IDX_HOUR: sel_data = {3'b000, now.hour};
            IDX_DOW:  sel_data = {5'b00000, now.dow};
            IDX_DOM:  sel_data = {3'b000, now.dom};
            IDX_MON:  sel_data = {4'b0000, now.mon};
            IDX_YEAR: sel_data = now.year - BIAS8;
            IDX_CTLA: sel_data = {uip, CTLA_LOW};
            IDX_CTLB: sel_data = CTLB_VALUE;
            IDX_CTLC: sel_data = CTLC_VALUE;
            default:  sel_ok   = 1'b0;
        endcase
    end

    assign read_a = data_rd && (idx == IDX_CTLA);

    // Index register, update flag, read result and error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx      <= 8'h00;
            uip      <= 1'b1;
            rd_data  <= 8'h00;
            rd_valid <= 1'b0;
            err      <= 1'b0;
        end else begin
            if (idx_wr) idx <= idx_wdata;
            if (read_a) uip <= ~uip;
            if (data_rd) rd_data <= sel_ok ? sel_data : 8'h00;
            rd_valid <= data_rd;
            err      <= (data_rd && !sel_ok) || data_wr;
        end
    end

    AST_IDX_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        idx_wr |=> idx == $past(idx_wdata)); // R1
    AST_UIP_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        read_a |=> uip != $past(uip)); // R2
    AST_UIP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !read_a |=> $stable(uip)); // R2
    AST_WRITE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        data_wr |=> err); // R6
    AST_BAD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !data_wr && !sel_ok) |=> (err && rd_valid && rd_data == 8'h00)); // R6

endmodule

// File: rtl/rtc_regfile.sv
`timescale 1ns/1ps
// Calendar clock register file top: packs the preset pins into a calendar
// record and connects the calendar, the access port and the periodic
// interrupt generator.
// Assumes sec_tick and preset_load are single-cycle strobes from the same clock.
module rtc_regfile
    import rtc_regfile_pkg::*;
#(
    parameter int PERIOD_CYCLES = 1024,
    parameter int YEAR_BIAS     = 52,
    parameter int RESET_YEAR    = 70,
    parameter int RESET_DOW     = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sec_tick,
    input  logic       preset_load,
    input  logic [5:0] preset_sec,
    input  logic [5:0] preset_min,
    input  logic [4:0] preset_hour,
    input  logic [2:0] preset_dow,
    input  logic [4:0] preset_dom,
    input  logic [3:0] preset_mon,
    input  logic [7:0] preset_year,
    input  logic       idx_wr,
    input  logic [7:0] idx_wdata,
    input  logic       data_rd,
    input  logic       data_wr,
    output logic [7:0] rd_data,
    output logic       rd_valid,
    output logic       access_err,
    output logic       periodic_irq
);

    cal_t preset;
    cal_t now;

    // Gather the preset pins into one record.
    always_comb begin
        preset = '{sec: preset_sec, min: preset_min, hour: preset_hour,
                   dow: preset_dow, dom: preset_dom, mon: preset_mon,
                   year: preset_year};
    end

    rtc_calendar #(
        .RESET_YEAR (RESET_YEAR),
        .RESET_DOW  (RESET_DOW)
    ) u_calendar (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (sec_tick),
        .load   (preset_load),
        .preset (preset),
        .now    (now)
    );

    rtc_access #(
        .YEAR_BIAS (YEAR_BIAS)
    ) u_access (
        .clk       (clk),
        .rst_n     (rst_n),
        .idx_wr    (idx_wr),
        .idx_wdata (idx_wdata),
        .data_rd   (data_rd),
        .data_wr   (data_wr),
        .now       (now),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid),
        .err       (access_err)
    );

    rtc_periodic #(
        .PERIOD_CYCLES (PERIOD_CYCLES)
    ) u_periodic (
        .clk   (clk),
        .rst_n (rst_n),
        .irq   (periodic_irq)
    );

endmodule

// File: tb/rtc_regfile_test.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks queue expected read results, a monitor
// compares them when rd_valid rises; a second monitor times the interrupt.
module rtc_regfile_test;

    localparam int PERIOD = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sec_tick = 1'b0;
    logic       preset_load = 1'b0;
    logic [5:0] preset_sec = '0;
    logic [5:0] preset_min = '0;
    logic [4:0] preset_hour = '0;
    logic [2:0] preset_dow = '0;
    logic [4:0] preset_dom = '0;
    logic [3:0] preset_mon = '0;
    logic [7:0] preset_year = '0;
    logic       idx_wr = 1'b0;
    logic [7:0] idx_wdata = '0;
    logic       data_rd = 1'b0;
    logic       data_wr = 1'b0;
    logic [7:0] rd_data;
    logic       rd_valid;
    logic       access_err;
    logic       periodic_irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    logic [7:0] exp_q[$];
    logic       err_q[$];
    string      tag_q[$];

    rtc_regfile #(.PERIOD_CYCLES(PERIOD)) uut (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .preset_load(preset_load),
        .preset_sec(preset_sec), .preset_min(preset_min), .preset_hour(preset_hour),
        .preset_dow(preset_dow), .preset_dom(preset_dom), .preset_mon(preset_mon),
        .preset_year(preset_year), .idx_wr(idx_wr), .idx_wdata(idx_wdata),
        .data_rd(data_rd), .data_wr(data_wr), .rd_data(rd_data), .rd_valid(rd_valid),
        .access_err(access_err), .periodic_irq(periodic_irq)
    );

    always #4 clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Read monitor: pops one expected item per rd_valid pulse.
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                check(0, "unexpected rd_valid", 1, 0);
            end else begin
                logic [7:0] e;
                logic       ee;
                string      t;
                e  = exp_q.pop_front();
                ee = err_q.pop_front();
                t  = tag_q.pop_front();
                check(rd_data == e, t, rd_data, e);
                check(access_err == ee, {t, " err"}, access_err, ee);
            end
        end
    end

    // Interrupt monitor: first pulse and spacing (R10).
    int cyc = 0;
    int last_pulse = 0;
    int n_pulses = 0;
    logic irq_prev = 1'b0;
    always @(posedge clk) if (rst_n) cyc <= cyc + 1;
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (periodic_irq) begin
                if (n_pulses == 0) check(cyc == PERIOD, "R10 first pulse cycle", cyc, PERIOD);
                else check(cyc - last_pulse == PERIOD, "R10 pulse spacing", cyc - last_pulse, PERIOD);
                if (irq_prev) check(0, "R10 pulse width", 2, 1);
                last_pulse = cyc;
                n_pulses++;
            end
            irq_prev = periodic_irq;
        end
    end

    task automatic read_reg(input bit set_idx, input logic [7:0] idx,
                            input logic [7:0] exp, input logic exp_err, input string tag);
        if (set_idx) begin
            @(negedge clk); idx_wr = 1'b1; idx_wdata = idx;
            @(negedge clk); idx_wr = 1'b0;
        end else begin
            @(negedge clk);
        end
        data_rd = 1'b1;
        exp_q.push_back(exp); err_q.push_back(exp_err); tag_q.push_back(tag);
        @(negedge clk); data_rd = 1'b0;
        @(negedge clk);
    endtask

    task automatic load_time(input int s, input int m, input int h, input int dw,
                             input int dm, input int mo, input int y, input bit with_tick);
        @(negedge clk);
        preset_sec = 6'(s); preset_min = 6'(m); preset_hour = 5'(h); preset_dow = 3'(dw);
        preset_dom = 5'(dm); preset_mon = 4'(mo); preset_year = 8'(y);
        preset_load = 1'b1; sec_tick = with_tick;
        @(negedge clk); preset_load = 1'b0; sec_tick = 1'b0;
    endtask

    task automatic tick_once();
        @(negedge clk); sec_tick = 1'b1;
        @(negedge clk); sec_tick = 1'b0;
    endtask

    task automatic read_cal(input int s, input int m, input int h, input int dw,
                            input int dm, input int mo, input int y, input string tag);
        read_reg(1, 8'h00, 8'(s),      0, {tag, " R1 sec"});
        read_reg(1, 8'h02, 8'(m),      0, {tag, " R1 min"});
        read_reg(1, 8'h04, 8'(h),      0, {tag, " R1 hour"});
        read_reg(1, 8'h06, 8'(dw),     0, {tag, " R1 dow"});
        read_reg(1, 8'h07, 8'(dm),     0, {tag, " R1 dom"});
        read_reg(1, 8'h08, 8'(mo),     0, {tag, " R4 month"});
        read_reg(1, 8'h09, 8'(y - 52), 0, {tag, " R5 year"});
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset outputs and calendar
        check(rd_valid == 1'b0, "R11 rd_valid", rd_valid, 0);
        check(access_err == 1'b0, "R11 access_err", access_err, 0);
        check(periodic_irq == 1'b0, "R11 periodic_irq", periodic_irq, 0);
        read_cal(0, 0, 0, 4, 1, 1, 70, "R11 reset");

        // R2, R3: control registers, index reuse without rewriting (R1)
        read_reg(1, 8'h0A, 8'hA6, 0, "R2 first A read");
        read_reg(0, 8'h0A, 8'h26, 0, "R2 second A read (R1 index kept)");
        read_reg(1, 8'h0B, 8'h46, 0, "R3 B value");
        read_reg(1, 8'h0C, 8'h00, 0, "R3 C value");
        read_reg(1, 8'h0A, 8'hA6, 0, "R2 third A read");

        // R7, R8, R9: year rollover from Dec 31 23:59:58
        load_time(58, 59, 23, 6, 31, 12, 99, 0);
        read_cal(58, 59, 23, 6, 31, 12, 99, "R7 preset");
        tick_once();
        read_reg(1, 8'h00, 8'd59, 0, "R8 sec advance");
        tick_once();
        read_cal(0, 0, 0, 0, 1, 1, 100, "R9 year carry");

        // R8: minute carry only
        load_time(59, 20, 10, 2, 15, 6, 120, 0);
        tick_once();
        read_cal(0, 21, 10, 2, 15, 6, 120, "R8 minute carry");

        // R9: leap and non-leap February, century year, 30-day month
        load_time(59, 59, 23, 1, 28, 2, 100, 0);
        tick_once();
        read_cal(0, 0, 0, 2, 29, 2, 100, "R9 leap Feb 28");
        load_time(59, 59, 23, 2, 29, 2, 100, 0);
        tick_once();
        read_cal(0, 0, 0, 3, 1, 3, 100, "R9 leap Feb 29");
        load_time(59, 59, 23, 3, 28, 2, 101, 0);
        tick_once();
        read_cal(0, 0, 0, 4, 1, 3, 101, "R9 plain Feb 28");
        load_time(59, 59, 23, 3, 28, 2, 0, 0);
        tick_once();
        read_cal(0, 0, 0, 4, 1, 3, 0, "R9 century Feb 28 (R5 wrap)");
        load_time(59, 59, 23, 5, 30, 4, 110, 0);
        tick_once();
        read_cal(0, 0, 0, 6, 1, 5, 110, "R9 30-day month");

        // R7: load wins over a simultaneous tick
        load_time(10, 11, 12, 3, 13, 7, 90, 1);
        read_cal(10, 11, 12, 3, 13, 7, 90, "R7 load with tick");

        // R6: unsupported reads and data write
        read_reg(1, 8'h0D, 8'h00, 1, "R6 register D");
        read_reg(1, 8'h01, 8'h00, 1, "R6 alarm slot");
        read_reg(1, 8'h3F, 8'h00, 1, "R6 unknown index");
        read_reg(1, 8'h00, 8'd10, 0, "R6 valid read after errors");
        @(negedge clk); data_wr = 1'b1;
        @(negedge clk); data_wr = 1'b0;
        check(access_err == 1'b1, "R6 data write error", access_err, 1);
        check(rd_valid == 1'b0, "R6 data write no read", rd_valid, 0);
        read_reg(0, 8'h00, 8'd10, 0, "R6 seconds unchanged by data write");

        repeat (PERIOD * 2) @(negedge clk);
        check(n_pulses >= 3, "R10 pulses seen", n_pulses, 3);
        check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
        done = 1;
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            check(0, "watchdog expired", 0, 1);
            finish_run();
        end
    end

endmodule